// File: doc/BRIEF.md
# Control Line Transition Limiter

This block conditions three slow video control lines, such as sync and enable strobes, on their way into a link transmitter. Each line may only change its output a limited number of times per 130-clock frame. The first two lines can also be told to ignore glitches shorter than three clocks. The third line has a stricter budget, and after it changes it must hold the new level for a minimum time. Whenever a wanted change is refused, the block pulses a per-line flag.

Time is divided into fixed, back-to-back frames of 130 clocks, counted by a free-running counter. Each line's budget refills at the start of every frame. A change that is refused leaves the output at its old level. That line is then not looked at again until the next frame, when the raw input is evaluated afresh. A two-bit mode input picks unfiltered limiting, filtered limiting, or a plain registered bypass.

Top module: `ctl_xition_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears `ctl_out` and `drop_flag` to 0.
- R2: With `mode_sel` = 2'b00, a new raw level on line 1 (`ctl_raw[0]`) or line 2 (`ctl_raw[1]`) appears on the output after the edge that samples it (one clock). A single-clock pulse is enough.
- R3: Lines 1 and 2 each change their output at most twice per frame. A change beyond that is refused: the output keeps its level and that line's `drop_flag` bit is high for exactly one clock.
- R4: After a refusal, the line ignores its raw input for the rest of the frame and raises no further flag. At the first edge of the next frame the raw level is evaluated again.
- R5: Frames are 130 clocks long. The first edge with `rst_n` high starts a frame, so frames start at edges 0, 130, 260 and so on after reset.
- R6: With `mode_sel` = 2'b01, a level on line 1 or 2 is accepted only at the third consecutive edge that samples it. A pulse seen by fewer than three edges changes nothing, raises no flag and uses no budget.
- R7: Line 3 (`ctl_raw[2]`) changes its output at most once per frame. A second change in the same frame is refused and flagged, as in R3 and R4.
- R8: After line 3 changes at edge e, its output cannot change again before edge e+130. A change blocked by this hold is refused and flagged, even at the start of a new frame.
- R9: With `mode_sel` = 2'b10 or 2'b11, every output follows its raw input one clock later, with no limit, and `drop_flag` stays 0.
- R10: A reset in mid-operation restores every budget and releases the line 3 hold, so the first change after reset passes on every line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | 00 limit only, 01 limit with glitch filter, 1x bypass |
| ctl_raw | input | 3 | Raw control lines; bit 0 is line 1, bit 2 is line 3 |
| ctl_out | output | 3 | Conditioned control lines |
| drop_flag | output | 3 | One-clock pulse per line when a change is refused |

## Verification
A budget counter holding a wrong value shows up within the same frame. A change either passes where it should have been flagged, or is flagged where it should have passed. A frame counter with the wrong phase moves the refill point away from edge 130 and shifts when blocked levels finally appear. A wrong line 3 hold timer is only seen at a frame boundary, so it can take up to 260 clocks to appear. A qualifier history in the wrong state makes filtered lines early or late by a clock, or lets a two-clock glitch through.

// File: rtl/ctlf_pkg.sv
// Shared types for the control line transition limiter.
// Assumes: mode codes are fixed by the pin strapping of the surrounding chip.
package ctlf_pkg;
    typedef enum logic [1:0] {
        CM_LIMIT      = 2'b00,
        CM_LIMIT_FILT = 2'b01,
        CM_BYPASS_A   = 2'b10,
        CM_BYPASS_B   = 2'b11
    } ctl_mode_e;
endpackage

// File: rtl/ctlf_frame_timer.sv
// Free-running frame counter. It marks the first clock of each frame.
// Assumes: FRAME_LEN >= 2. The count restarts at 0 on reset.
module ctlf_frame_timer #(
    parameter int FRAME_LEN = 130
) (
    input  logic clk,
    input  logic rst_n,
    output logic frame_start
);
    localparam int CW = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles within a frame and wrap at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign frame_start = (cnt_q == '0);

    p_frame_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST) |=> (cnt_q == '0));
    p_frame_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/ctlf_line.sv
// One conditioned control line. It applies an optional minimum-pulse
// qualifier, a per-frame change budget and an optional hold after a change.
// Assumes: frame_start is high on the first cycle of each frame and
// MIN_PULSE >= 2. HOLD_LEN = 0 removes the hold timer.
module ctlf_line #(
    parameter int BUDGET    = 2,
    parameter int MIN_PULSE = 3,
    parameter int HOLD_LEN  = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic byp,
    input  logic qual_en,
    input  logic raw,
    output logic out_o,
    output logic drop_o
);
    localparam int UW = $clog2(BUDGET + 1);
    localparam int QD = MIN_PULSE - 1;

    logic          out_q, drop_q, blocked_q;
    logic [UW-1:0] used_q, used_eff;
    logic [QD-1:0] hist_q;
    logic          stable, blocked_eff, want, allow, take, hold_busy;

    // Shift in the most recent raw samples for the qualifier.
    generate
        if (QD == 1) begin : g_hist1
            always_ff @(posedge clk) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= raw;
            end
        end else begin : g_histn
            always_ff @(posedge clk) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= {hist_q[QD-2:0], raw};
            end
        end
    endgenerate

    // A level counts as a candidate once it has been seen MIN_PULSE times.
    always_comb begin
        stable      = qual_en ? (hist_q == {QD{raw}}) : 1'b1;
        used_eff    = frame_start ? '0 : used_q;
        blocked_eff = frame_start ? 1'b0 : blocked_q;
        want        = !byp && stable && (raw != out_q) && !blocked_eff;
        allow       = (used_eff < UW'(BUDGET)) && !hold_busy;
        take        = want && allow;
    end

    // Hold timer: after a change, further changes wait HOLD_LEN clocks.
    generate
        if (HOLD_LEN > 0) begin : g_hold
            localparam int HW = (HOLD_LEN > 1) ? $clog2(HOLD_LEN + 1) : 1;
            logic [HW-1:0] hold_q;

            // Load on an accepted change, then count down to zero.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hold_q <= '0;
                else if (take)
                    hold_q <= HW'(HOLD_LEN - 1);
                else if (hold_q != '0)
                    hold_q <= hold_q - 1'b1;
            end
            assign hold_busy = (hold_q != '0);

            p_hold_keeps_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (hold_busy && !byp) |=> $stable(out_q));
        end else begin : g_nohold
            assign hold_busy = 1'b0;
        end
    endgenerate

    // Output, budget and refusal state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q     <= 1'b0;
            drop_q    <= 1'b0;
            used_q    <= '0;
            blocked_q <= 1'b0;
        end else begin
            drop_q    <= 1'b0;
            used_q    <= used_eff;
            blocked_q <= blocked_eff;
            if (byp) begin
                out_q <= raw;
            end else if (take) begin
                out_q  <= raw;
                used_q <= used_eff + 1'b1;
            end else if (want) begin
                drop_q    <= 1'b1;
                blocked_q <= 1'b1;
            end
        end
    end

    assign out_o  = out_q;
    assign drop_o = drop_q;

    p_drop_holds_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drop_q |-> $stable(out_q));
    p_drop_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_q && !frame_start) |=> !drop_q);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        used_q <= UW'(BUDGET));
    p_glitch_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_en && !byp && (raw != hist_q[0])) |=> $stable(out_q));
endmodule

// File: rtl/ctl_xition_filter.sv
// Top level of the control line transition limiter. The lower NUM_FAST lines
// use the fast budget and can be glitch filtered. The top line uses the slow
// budget and a hold time.
// Assumes: mode_sel is quasi-static; a mode change takes effect at the next edge.
module ctl_xition_filter #(
    parameter int NUM_FAST    = 2,
    parameter int FRAME_LEN   = 130,
    parameter int FAST_BUDGET = 2,
    parameter int SLOW_BUDGET = 1,
    parameter int MIN_PULSE   = 3,
    parameter int SLOW_HOLD   = 130,
    localparam int NL         = NUM_FAST + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel,
    input  logic [NL-1:0] ctl_raw,
    output logic [NL-1:0] ctl_out,
    output logic [NL-1:0] drop_flag
);
    import ctlf_pkg::*;

    logic      frame_start, byp, qual_en;
    ctl_mode_e mode;

    // Decode the mode select.
    always_comb begin
        mode    = ctl_mode_e'(mode_sel);
        byp     = (mode == CM_BYPASS_A) || (mode == CM_BYPASS_B);
        qual_en = (mode == CM_LIMIT_FILT);
    end

    ctlf_frame_timer #(.FRAME_LEN(FRAME_LEN)) frame_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start)
    );

    generate
        for (genvar i = 0; i < NL; i++) begin : g_line
            if (i < NUM_FAST) begin : g_fast
                ctlf_line #(.BUDGET(FAST_BUDGET), .MIN_PULSE(MIN_PULSE), .HOLD_LEN(0)) line_i (
                    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byp(byp),
                    .qual_en(qual_en), .raw(ctl_raw[i]),
                    .out_o(ctl_out[i]), .drop_o(drop_flag[i]));
            end else begin : g_slow
                ctlf_line #(.BUDGET(SLOW_BUDGET), .MIN_PULSE(MIN_PULSE), .HOLD_LEN(SLOW_HOLD)) line_i (
                    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byp(byp),
                    .qual_en(1'b0), .raw(ctl_raw[i]),
                    .out_o(ctl_out[i]), .drop_o(drop_flag[i]));
            end
        end
    endgenerate

    p_bypass_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        byp |=> (ctl_out == $past(ctl_raw)));
    p_bypass_nodrop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        byp |=> (drop_flag == '0));
endmodule

// File: tb/ctl_xition_filter_tb.sv
// Directed bench for the control line transition limiter: one task per scenario.
module ctl_xition_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [2:0] ctl_raw = 3'b000;
    logic [2:0] ctl_out, drop_flag;

    int checks = 0;
    int failures = 0;
    int edge_n = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    // Count edges since reset release; edge k is the (k+1)-th edge with rst_n high.
    always @(posedge clk) begin
        if (!rst_n) edge_n <= 0;
        else        edge_n <= edge_n + 1;
    end

    ctl_xition_filter dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .ctl_raw(ctl_raw), .ctl_out(ctl_out), .drop_flag(drop_flag));

    task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b (edge %0d)", tag, act, exp, edge_n);
        end
    endtask

    // Wait for the falling edge just before edge n (that is, after edge n-1).
    task automatic at_edge(int n);
        @(negedge clk);
        while (edge_n < n) @(negedge clk);
    endtask

    task automatic do_reset(logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; ctl_raw = 3'b000; mode_sel = m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0; ctl_raw = 3'b111; mode_sel = 2'b00;
        repeat (2) @(negedge clk);
        chk("R1 out", ctl_out, 3'b000);
        chk("R1 drop", drop_flag, 3'b000);
    endtask

    task automatic t_fast_budget();
        do_reset(2'b00);
        at_edge(5);  ctl_raw[0] = 1'b1;
        at_edge(6);  chk("R2 rise 1clk", ctl_out, 3'b001);
        ctl_raw[0] = 1'b0;
        at_edge(7);  chk("R2 short pulse", ctl_out, 3'b000);
        at_edge(10); ctl_raw[0] = 1'b1;
        at_edge(11); chk("R3 third dropped out", ctl_out, 3'b000);
        chk("R3 drop pulse", drop_flag, 3'b001);
        at_edge(12); chk("R4 no repeat flag", drop_flag, 3'b000);
        chk("R4 still held", ctl_out, 3'b000);
        at_edge(130); chk("R5 held to frame end", ctl_out, 3'b000);
        at_edge(131); chk("R5 re-evaluated at 130", ctl_out, 3'b001);
        chk("R4 no flag on retry", drop_flag, 3'b000);
    endtask

    task automatic t_filter();
        do_reset(2'b01);
        at_edge(5);  ctl_raw[1] = 1'b1;
        at_edge(7);  ctl_raw[1] = 1'b0;
        at_edge(9);  chk("R6 two-clock glitch out", ctl_out, 3'b000);
        chk("R6 glitch no flag", drop_flag, 3'b000);
        at_edge(20); ctl_raw[1] = 1'b1;
        at_edge(22); chk("R6 not before third edge", ctl_out, 3'b000);
        at_edge(23); chk("R6 accepted at third edge", ctl_out, 3'b010);
        at_edge(40); ctl_raw[1] = 1'b0;
        at_edge(43); chk("R6 glitch used no budget", ctl_out, 3'b000);
        at_edge(60); ctl_raw[1] = 1'b1;
        at_edge(63); chk("R3 filtered third dropped", drop_flag, 3'b010);
        chk("R3 filtered third out", ctl_out, 3'b000);
    endtask

    task automatic t_slow_line();
        do_reset(2'b00);
        at_edge(5);  ctl_raw[2] = 1'b1;
        at_edge(6);  chk("R7 first change", ctl_out, 3'b100);
        at_edge(10); ctl_raw[2] = 1'b0;
        at_edge(11); chk("R7 second dropped", drop_flag, 3'b100);
        chk("R7 level kept", ctl_out, 3'b100);
        at_edge(131); chk("R8 hold blocks at frame start", drop_flag, 3'b100);
        chk("R8 level kept", ctl_out, 3'b100);
        at_edge(132); chk("R4 single flag", drop_flag, 3'b000);
        at_edge(260); chk("R8 still held", ctl_out, 3'b100);
        at_edge(261); chk("R8 released next frame", ctl_out, 3'b000);
    endtask

    task automatic t_bypass();
        do_reset(2'b10);
        for (int i = 0; i < 12; i++) begin
            logic [2:0] pat;
            pat = i[0] ? 3'b010 : 3'b101;
            if (i == 8) mode_sel = 2'b11;
            at_edge(3 + i); ctl_raw = pat;
            at_edge(4 + i);
            chk("R9 follows raw", ctl_out, pat);
            chk("R9 no drop", drop_flag, 3'b000);
        end
    endtask

    task automatic t_reset_restore();
        do_reset(2'b00);
        at_edge(5);  ctl_raw = 3'b101;
        at_edge(6);  ctl_raw = 3'b100;
        at_edge(10); ctl_raw = 3'b001;
        at_edge(11); chk("R10 pre-reset drops", drop_flag, 3'b101);
        at_edge(20); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 cleared by reset", ctl_out, 3'b000);
        rst_n = 1'b1;
        at_edge(1);  chk("R10 budget restored", ctl_out, 3'b001);
        at_edge(2);  ctl_raw[2] = 1'b1;
        at_edge(3);  chk("R10 hold released", ctl_out, 3'b101);
    endtask

    initial begin
        t_reset_state();
        t_fast_budget();
        t_filter();
        t_slow_line();
        t_bypass();
        t_reset_restore();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule